// File: doc/BRIEF.md
# Redial and Store Number Controller

This block sits between a keypad decoder and a tone or pulse dialer in a telephone. It keeps a log of the numbers keyed during a call, so the last number can be dialled again. It also keeps a save buffer, three one-key slots and ten two-key slots. The keyed digits pass through it to the dialer one at a time over a valid/ready stream. Two special entries can sit inside a stored sequence: a wait marker and a pulse-to-tone marker. When a wait marker is played back, the block raises a pause request for a fixed number of cycles and puts nothing on the stream.

One key has two meanings. Pressed as the first key after going off-hook or after a flash, it replays the logged number. Pressed at any other point, it inserts a wait. Store procedures copy a sequence into a slot. The source is either the digits just dialled (store, store, slot) or digits keyed while storing (store, digits, store, slot), which are not dialled. A change of hook state or a flash-done event cancels any store in progress, aborts playback and returns the block to its first-key state.

Top module: `redial_store_ctrl`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with `offHook` low, `digitValid` and `pauseReq` are low. Keys pressed while `offHook` is low produce no output.
- R2: Key codes on `keyCode` are: 0–9 for digits, 10 for star, 11 for hash, 12 for redial/pause, 13 for store, 14 for save, 15 for pulse-to-tone, 16–18 for one-key slots 1–3 and 19 for the two-key prefix. A digit key pressed while dialling puts its code on the stream the cycle after the key is taken. `digitValid` and `digitCode` then hold steady until `digitReady` is seen high.
- R3: The redial/pause key pressed as the first key after going off-hook replays, in order, every entry keyed during the previous call, waits included.
- R4: The redial/pause key pressed after any other key puts nothing on the stream. It raises `pauseReq` for exactly PAUSE_CYCLES cycles and adds a wait to the log.
- R5: A call of exactly DEPTH entries is replayed in full by a later redial. After more than DEPTH entries, a later first-key redial produces no output at all.
- R6: The sequence store, entries, store, one-key slot N puts nothing on the stream. Pressing slot N later plays those entries in order.
- R7: A wait keyed as the first entry of a store is dropped. A wait keyed later is kept and replayed as a `pauseReq` window of PAUSE_CYCLES cycles.
- R8: After digits have been dialled, the sequence store, store, slot key copies the dialled entries into the slot without dialling them again.
- R9: A flash-done pulse or a hook change during a store cancels it. The next digit key is dialled normally.
- R10: The save key pressed after dialling copies the logged call into the save buffer and puts nothing on the stream. The save key pressed as the first key of a later call plays that buffer.
- R11: The two-key prefix followed by digit d selects two-key slot d, both for storing and for dialling.
- R12: Keys that arrive while a playback is running are ignored.
- R13: Stream codes are 0–9 for digits, 10 for star, 11 for hash and 13 for pulse-to-tone. The wait code (12) and the end code (15) never appear with `digitValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyValid | input | 1 | One-cycle strobe for a decoded key event |
| keyCode | input | 5 | Decoded key, encoded as in R2 |
| offHook | input | 1 | High while the handset is off-hook |
| flashDone | input | 1 | One-cycle pulse when a flash has completed |
| digitReady | input | 1 | Dialer accepts the current stream entry |
| digitValid | output | 1 | Stream entry is present |
| digitCode | output | 4 | Stream entry code, as in R13 |
| pauseReq | output | 1 | High while a stored or keyed wait is running |

## Verification
A corrupted log pointer or end marker shows up at the ports on the next first-key redial. The replay then comes out too short, too long or with entries in the wrong order. A store that writes the wrong slot or the wrong source shows only when that slot is dialled, so each store is followed at once by a dial of the same slot. A wrong state in the key-decoding machine shows within one key press, as a digit that is dialled when it should be silent, or the reverse. A wrong pause counter shows as a `pauseReq` window of the wrong length on the first wait.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  // stream cell codes
  localparam logic [3:0] CODE_STAR  = 4'd10;
  localparam logic [3:0] CODE_HASH  = 4'd11;
  localparam logic [3:0] CODE_PAUSE = 4'd12;
  localparam logic [3:0] CODE_PTT   = 4'd13;
  localparam logic [3:0] CODE_END   = 4'd15;

  // key codes
  localparam logic [4:0] KEY_STAR  = 5'd10;
  localparam logic [4:0] KEY_HASH  = 5'd11;
  localparam logic [4:0] KEY_RP    = 5'd12;
  localparam logic [4:0] KEY_STORE = 5'd13;
  localparam logic [4:0] KEY_SAVE  = 5'd14;
  localparam logic [4:0] KEY_PTT   = 5'd15;
  localparam logic [4:0] KEY_M1    = 5'd16;
  localparam logic [4:0] KEY_M3    = 5'd18;
  localparam logic [4:0] KEY_IND   = 5'd19;

  // buffer map
  localparam int N_ONE       = 3;
  localparam int N_TWO       = 10;
  localparam int BUF_REDIAL  = 0;
  localparam int BUF_SAVE    = 1;
  localparam int BUF_ONE0    = 2;
  localparam int BUF_TWO0    = BUF_ONE0 + N_ONE;
  localparam int BUF_SCRATCH = BUF_TWO0 + N_TWO;
  localparam int N_BUF       = BUF_SCRATCH + 1;
  localparam int BUF_W       = $clog2(N_BUF);

  typedef logic [BUF_W-1:0] bufIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       recAppend;
    logic       recRestart;
    logic       scrClear;
    logic       scrAppend;
    logic       copyEn;
    bufIdx_t    copySrc;
    bufIdx_t    copyDst;
    logic [3:0] code;
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_FIRST, ST_DIAL, ST_IND_DIAL, ST_STORE_ARM,
    ST_STORE_DIG, ST_STORE_SLOT, ST_STORE_IND
  } ctrlState_t;

  typedef enum logic [1:0] {P_IDLE, P_RUN, P_PAUSE} playState_t;

endpackage

// File: rtl/rdl_datapath.sv
module rdl_datapath
  import rdl_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  bufIdx_t          rdBuf,
  input  logic [CNT_W-1:0] rdPtr,
  output logic [3:0]       rdCode,
  output logic             recInvalid,
  output logic [CNT_W-1:0] scrCount
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [3:0]       mem [N_BUF][DEPTH];
  logic [CNT_W-1:0] recCount;
  logic [CNT_W-1:0] recBase;
  logic [CNT_W-1:0] recNext;
  logic [CNT_W-1:0] scrNext;

  always_comb begin
    recBase = cmd.recRestart ? '0 : recCount;
    recNext = recBase + ONE_C;
    scrNext = scrCount + ONE_C;
  end

  assign rdCode = (rdPtr < DEPTH_C) ? mem[rdBuf][rdPtr[PTR_W-1:0]] : CODE_END;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < N_BUF; b++) begin
        for (int i = 0; i < DEPTH; i++) begin
          mem[b][i] <= CODE_END;
        end
      end
      recCount   <= '0;
      recInvalid <= 1'b0;
      scrCount   <= '0;
    end else begin
      if (cmd.copyEn) begin
        for (int i = 0; i < DEPTH; i++) begin
          mem[cmd.copyDst][i] <= mem[cmd.copySrc][i];
        end
      end
      if (cmd.recAppend) begin
        if (recBase < DEPTH_C) begin
          mem[BUF_REDIAL][recBase[PTR_W-1:0]] <= cmd.code;
          if (recNext < DEPTH_C) begin
            mem[BUF_REDIAL][recNext[PTR_W-1:0]] <= CODE_END;
          end
          recCount <= recNext;
          if (cmd.recRestart) begin
            recInvalid <= 1'b0;
          end
        end else begin
          recInvalid <= 1'b1;
        end
      end
      if (cmd.scrClear) begin
        mem[BUF_SCRATCH][0] <= CODE_END;
        scrCount            <= '0;
      end else if (cmd.scrAppend && (scrCount < DEPTH_C)) begin
        mem[BUF_SCRATCH][scrCount[PTR_W-1:0]] <= cmd.code;
        if (scrNext < DEPTH_C) begin
          mem[BUF_SCRATCH][scrNext[PTR_W-1:0]] <= CODE_END;
        end
        scrCount <= scrNext;
      end
    end
  end

  // R7
  scratch_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    mem[BUF_SCRATCH][0] != CODE_PAUSE);

  // R5
  invalid_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    recInvalid |-> (recCount == DEPTH_C));

endmodule

// File: rtl/rdl_control.sv
module rdl_control
  import rdl_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int PAUSE_CYCLES = 3600000,
  parameter int CNT_W        = $clog2(DEPTH + 1),
  parameter int PCNT_W       = $clog2(PAUSE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyValid,
  input  logic [4:0]       keyCode,
  input  logic             offHook,
  input  logic             flashDone,
  input  logic             digitReady,
  output logic             digitValid,
  output logic [3:0]       digitCode,
  output logic             pauseReq,
  output dpCmd_t           cmd,
  output bufIdx_t          rdBuf,
  output logic [CNT_W-1:0] rdPtr,
  input  logic [3:0]       rdCode,
  input  logic             recInvalid,
  input  logic [CNT_W-1:0] scrCount
);

  localparam logic [CNT_W-1:0]  DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [PCNT_W-1:0] PLOAD_C  = PCNT_W'(PAUSE_CYCLES - 1);

  ctrlState_t       cState, nextState;
  playState_t       pState;
  bufIdx_t          storeSrc, nextSrc, startBuf, playBuf;
  logic             offHookQ, hookChange, abort, busy, keyAcc;
  logic             recFresh, clrFresh, startPlay, startOne;
  logic             isDigit, isDial, isMem;
  logic [3:0]       keyCell, oneReg, curCode;
  logic             oneShot, endHit;
  logic [CNT_W-1:0] playPtr;
  logic [PCNT_W-1:0] pauseCnt;
  bufIdx_t          memSlot, twoSlot;

  assign hookChange = offHook != offHookQ;
  assign abort      = hookChange || flashDone || !offHook;
  assign busy       = pState != P_IDLE;
  assign keyAcc     = keyValid && !busy && !abort;

  assign isDigit = keyCode <= 5'd9;
  assign isDial  = isDigit || (keyCode == KEY_STAR) || (keyCode == KEY_HASH) ||
                   (keyCode == KEY_PTT);
  assign isMem   = (keyCode >= KEY_M1) && (keyCode <= KEY_M3);
  assign memSlot = bufIdx_t'(BUF_ONE0) + bufIdx_t'(keyCode - KEY_M1);
  assign twoSlot = bufIdx_t'(BUF_TWO0) + bufIdx_t'(keyCode);

  always_comb begin
    if (isDigit)                   keyCell = keyCode[3:0];
    else if (keyCode == KEY_STAR)  keyCell = CODE_STAR;
    else if (keyCode == KEY_HASH)  keyCell = CODE_HASH;
    else if (keyCode == KEY_PTT)   keyCell = CODE_PTT;
    else if (keyCode == KEY_RP)    keyCell = CODE_PAUSE;
    else                           keyCell = CODE_END;
  end

  // key interpretation
  always_comb begin
    cmd            = '0;
    cmd.code       = keyCell;
    cmd.recRestart = recFresh;
    nextState      = cState;
    nextSrc        = storeSrc;
    startPlay      = 1'b0;
    startOne       = 1'b0;
    startBuf       = bufIdx_t'(BUF_REDIAL);
    clrFresh       = 1'b0;
    if (keyAcc) begin
      case (cState)
        ST_FIRST, ST_DIAL: begin
          if (isDial) begin
            cmd.recAppend = 1'b1;
            startOne      = 1'b1;
            clrFresh      = 1'b1;
            nextState     = ST_DIAL;
          end else if (keyCode == KEY_RP) begin
            if (cState == ST_FIRST) begin
              if (!recInvalid) begin
                startPlay = 1'b1;
                clrFresh  = 1'b1;
                nextState = ST_DIAL;
              end
            end else begin
              cmd.recAppend = 1'b1;
              startOne      = 1'b1;
              clrFresh      = 1'b1;
            end
          end else if (keyCode == KEY_STORE) begin
            if (cState == ST_FIRST) begin
              cmd.scrClear = 1'b1;
              nextState    = ST_STORE_DIG;
            end else begin
              nextState = ST_STORE_ARM;
            end
          end else if (keyCode == KEY_SAVE) begin
            if (cState == ST_FIRST) begin
              startPlay = 1'b1;
              startBuf  = bufIdx_t'(BUF_SAVE);
              nextState = ST_DIAL;
            end else begin
              cmd.copyEn  = 1'b1;
              cmd.copySrc = bufIdx_t'(BUF_REDIAL);
              cmd.copyDst = bufIdx_t'(BUF_SAVE);
            end
          end else if (isMem) begin
            startPlay = 1'b1;
            startBuf  = memSlot;
            nextState = ST_DIAL;
          end else if (keyCode == KEY_IND) begin
            nextState = ST_IND_DIAL;
          end
        end
        ST_IND_DIAL: begin
          if (isDigit) begin
            startPlay = 1'b1;
            startBuf  = twoSlot;
          end
          nextState = ST_DIAL;
        end
        ST_STORE_ARM: begin
          if (keyCode == KEY_STORE) begin
            nextSrc   = bufIdx_t'(BUF_REDIAL);
            nextState = ST_STORE_SLOT;
          end
        end
        ST_STORE_DIG: begin
          if (isDial || ((keyCode == KEY_RP) && (scrCount != '0))) begin
            cmd.scrAppend = 1'b1;
          end else if (keyCode == KEY_STORE) begin
            nextSrc   = bufIdx_t'(BUF_SCRATCH);
            nextState = ST_STORE_SLOT;
          end
        end
        ST_STORE_SLOT: begin
          cmd.copySrc = storeSrc;
          if (isMem) begin
            cmd.copyEn  = 1'b1;
            cmd.copyDst = memSlot;
            nextState   = ST_DIAL;
          end else if (keyCode == KEY_SAVE) begin
            cmd.copyEn  = 1'b1;
            cmd.copyDst = bufIdx_t'(BUF_SAVE);
            nextState   = ST_DIAL;
          end else if (keyCode == KEY_IND) begin
            nextState = ST_STORE_IND;
          end
        end
        ST_STORE_IND: begin
          cmd.copySrc = storeSrc;
          if (isDigit) begin
            cmd.copyEn  = 1'b1;
            cmd.copyDst = twoSlot;
            nextState   = ST_DIAL;
          end
        end
        default: nextState = ST_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cState   <= ST_FIRST;
      storeSrc <= bufIdx_t'(BUF_REDIAL);
      recFresh <= 1'b1;
      offHookQ <= 1'b0;
    end else begin
      offHookQ <= offHook;
      if (abort) begin
        cState <= ST_FIRST;
        if (hookChange || flashDone) begin
          recFresh <= 1'b1;
        end
      end else begin
        cState   <= nextState;
        storeSrc <= nextSrc;
        if (clrFresh) begin
          recFresh <= 1'b0;
        end
      end
    end
  end

  // playback engine
  assign curCode    = oneShot ? oneReg : rdCode;
  assign endHit     = !oneShot && ((playPtr == DEPTH_C) || (rdCode == CODE_END));
  assign digitValid = (pState == P_RUN) && !endHit && (curCode != CODE_PAUSE);
  assign digitCode  = curCode;
  assign pauseReq   = pState == P_PAUSE;
  assign rdBuf      = playBuf;
  assign rdPtr      = playPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pState   <= P_IDLE;
      playBuf  <= '0;
      playPtr  <= '0;
      oneShot  <= 1'b0;
      oneReg   <= CODE_END;
      pauseCnt <= '0;
    end else if (abort) begin
      pState <= P_IDLE;
    end else if (startPlay) begin
      pState  <= P_RUN;
      playBuf <= startBuf;
      playPtr <= '0;
      oneShot <= 1'b0;
    end else if (startOne) begin
      oneShot <= 1'b1;
      oneReg  <= keyCell;
      if (keyCell == CODE_PAUSE) begin
        pState   <= P_PAUSE;
        pauseCnt <= PLOAD_C;
      end else begin
        pState <= P_RUN;
      end
    end else begin
      case (pState)
        P_RUN: begin
          if (endHit) begin
            pState <= P_IDLE;
          end else if (curCode == CODE_PAUSE) begin
            pState   <= P_PAUSE;
            pauseCnt <= PLOAD_C;
          end else if (digitReady) begin
            if (oneShot) pState <= P_IDLE;
            else         playPtr <= playPtr + CNT_W'(1);
          end
        end
        P_PAUSE: begin
          if (pauseCnt == '0) begin
            if (oneShot) begin
              pState <= P_IDLE;
            end else begin
              pState  <= P_RUN;
              playPtr <= playPtr + CNT_W'(1);
            end
          end else begin
            pauseCnt <= pauseCnt - PCNT_W'(1);
          end
        end
        default: pState <= P_IDLE;
      endcase
    end
  end

  // pause window length tracker for the checker
  logic [PCNT_W:0] pauseRun;
  always_ff @(posedge clk) begin
    if (!rstN)         pauseRun <= '0;
    else if (pauseReq) pauseRun <= pauseRun + (PCNT_W+1)'(1);
    else               pauseRun <= '0;
  end

  // R2
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (digitValid && !digitReady && !abort) |=> (digitValid && $stable(digitCode)));

  // R4
  pause_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pauseReq) && !$past(abort)) |-> (pauseRun == (PCNT_W+1)'(PAUSE_CYCLES)));

  // R13
  stream_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    digitValid |-> ((digitCode != CODE_PAUSE) && (digitCode != CODE_END)));

  // R1
  onhook_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !offHook |=> (!digitValid && !pauseReq));

endmodule

// File: rtl/redial_store_ctrl.sv
module redial_store_ctrl
  import rdl_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int PAUSE_CYCLES = 3600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyValid,
  input  logic [4:0] keyCode,
  input  logic       offHook,
  input  logic       flashDone,
  input  logic       digitReady,
  output logic       digitValid,
  output logic [3:0] digitCode,
  output logic       pauseReq
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PCNT_W = $clog2(PAUSE_CYCLES + 1);

  dpCmd_t           cmd;
  bufIdx_t          rdBuf;
  logic [CNT_W-1:0] rdPtr;
  logic [3:0]       rdCode;
  logic             recInvalid;
  logic [CNT_W-1:0] scrCount;

  rdl_control #(
    .DEPTH(DEPTH), .PAUSE_CYCLES(PAUSE_CYCLES), .CNT_W(CNT_W), .PCNT_W(PCNT_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .offHook(offHook), .flashDone(flashDone), .digitReady(digitReady),
    .digitValid(digitValid), .digitCode(digitCode), .pauseReq(pauseReq),
    .cmd(cmd), .rdBuf(rdBuf), .rdPtr(rdPtr), .rdCode(rdCode),
    .recInvalid(recInvalid), .scrCount(scrCount)
  );

  rdl_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdBuf(rdBuf), .rdPtr(rdPtr),
    .rdCode(rdCode), .recInvalid(recInvalid), .scrCount(scrCount)
  );

endmodule

// File: tb/redial_store_ctrl_bench.sv
module redial_store_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int PCYC       = 6;

  localparam logic [4:0] K_STAR = 5'd10, K_HASH = 5'd11, K_RP = 5'd12,
                         K_STORE = 5'd13, K_SAVE = 5'd14, K_PTT = 5'd15,
                         K_M1 = 5'd16, K_M2 = 5'd17, K_M3 = 5'd18, K_IND = 5'd19;

  // {key, expected stream code}
  localparam logic [8:0] DIAL_TAB [13] = '{
    {5'd1, 4'd1}, {5'd2, 4'd2}, {5'd3, 4'd3}, {5'd4, 4'd4}, {5'd5, 4'd5},
    {5'd6, 4'd6}, {5'd7, 4'd7}, {5'd8, 4'd8}, {5'd9, 4'd9}, {5'd0, 4'd0},
    {K_STAR, 4'd10}, {K_HASH, 4'd11}, {K_PTT, 4'd13}
  };

  logic       clk = 1'b0;
  logic       rstN, keyValid, offHook, flashDone, digitReady;
  logic [4:0] keyCode;
  logic       digitValid, pauseReq;
  logic [3:0] digitCode;

  redial_store_ctrl #(.DEPTH(DEPTH), .PAUSE_CYCLES(PCYC)) u_redial_store_ctrl (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .offHook(offHook), .flashDone(flashDone), .digitReady(digitReady),
    .digitValid(digitValid), .digitCode(digitCode), .pauseReq(pauseReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         nChecks = 0;
  int         nFails  = 0;
  logic [3:0] obs  [80];
  logic [3:0] expv [80];
  int         obsN, expN, lastPause, quietSum;
  bit         done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expd);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expd);
    end
  endtask

  task automatic pressKey(input logic [4:0] k);
    keyCode  = k;
    keyValid = 1'b1;
    @(negedge clk);
    keyValid = 1'b0;
  endtask

  task automatic drain();
    int  idle = 0;
    int  run  = 0;
    bit  prevP = 1'b0;
    obsN = 0;
    digitReady = 1'b1;
    for (int n = 0; n < 400; n++) begin
      if (digitValid && digitReady && obsN < 80) begin
        obs[obsN] = digitCode;
        obsN++;
      end
      if (pauseReq) begin
        if (!prevP && obsN < 80) begin
          obs[obsN] = 4'd12;
          obsN++;
        end
        run++;
      end else if (prevP) begin
        lastPause = run;
        run = 0;
      end
      prevP = pauseReq;
      if (digitValid || pauseReq) idle = 0;
      else idle++;
      if (idle >= 4) break;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input logic [4:0] k);
    pressKey(k);
    drain();
    quietSum += obsN;
  endtask

  task automatic hookCycle();
    offHook = 1'b0;
    repeat (3) @(negedge clk);
    offHook = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic expClear();
    expN = 0;
  endtask

  task automatic expAdd(input logic [3:0] c);
    expv[expN] = c;
    expN++;
  endtask

  task automatic checkSeq(input string req);
    int bad = -1;
    check(obsN == expN, req, "sequence length", obsN, expN);
    for (int i = 0; i < obsN && i < expN; i++) begin
      if (bad < 0 && obs[i] != expv[i]) bad = i;
    end
    check(bad < 0, req, "code at first mismatch",
          (bad < 0) ? 0 : int'(obs[bad]), (bad < 0) ? 0 : int'(expv[bad]));
  endtask

  initial begin
    rstN = 1'b0; keyValid = 1'b0; keyCode = '0; offHook = 1'b0;
    flashDone = 1'b0; digitReady = 1'b1; lastPause = 0; quietSum = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!digitValid && !pauseReq, "R1", "outputs in reset", int'(digitValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 key while on-hook
    pressKey(5'd5);
    drain();
    check(obsN == 0, "R1", "on-hook key output count", obsN, 0);
    offHook = 1'b1;
    repeat (3) @(negedge clk);

    // R13 / R2 table walk
    for (int i = 0; i < 13; i++) begin
      pressKey(DIAL_TAB[i][8:4]);
      drain();
      check(obsN == 1, "R13", "entries per key", obsN, 1);
      check(obs[0] == DIAL_TAB[i][3:0], "R13", "stream code", int'(obs[0]),
            int'(DIAL_TAB[i][3:0]));
    end

    // R4 wait key mid-call
    pressKey(K_RP);
    drain();
    check(obsN == 1 && obs[0] == 4'd12, "R4", "only a pause window", obsN, 1);
    check(lastPause == PCYC, "R4", "pause window length", lastPause, PCYC);

    // R3 redial as first key
    hookCycle();
    pressKey(K_RP);
    drain();
    expClear();
    for (int i = 0; i < 13; i++) expAdd(DIAL_TAB[i][3:0]);
    expAdd(4'd12);
    checkSeq("R3");

    // R2 hold until taken
    begin
      bit ok = 1'b1;
      digitReady = 1'b0;
      pressKey(5'd7);
      repeat (4) begin
        if (!(digitValid && digitCode == 4'd7)) ok = 1'b0;
        @(negedge clk);
      end
      check(ok, "R2", "valid and code held while not ready", int'(digitCode), 7);
      drain();
      check(obsN == 1 && obs[0] == 4'd7, "R2", "single transfer", obsN, 1);
    end

    // R10 save copy then save play
    pressKey(K_SAVE);
    drain();
    check(obsN == 0, "R10", "save copy is silent", obsN, 0);
    hookCycle();
    pressKey(K_SAVE);
    drain();
    expAdd(4'd7);
    checkSeq("R10");

    // R6 / R7 store with digits keyed inside the store
    hookCycle();
    quietSum = 0;
    quiet(K_STORE); quiet(5'd4); quiet(5'd2); quiet(K_RP); quiet(5'd8);
    quiet(K_STORE); quiet(K_M2);
    check(quietSum == 0, "R6", "store procedure output count", quietSum, 0);
    lastPause = 0;
    pressKey(K_M2);
    drain();
    expClear(); expAdd(4'd4); expAdd(4'd2); expAdd(4'd12); expAdd(4'd8);
    checkSeq("R6");
    check(lastPause == PCYC, "R7", "stored pause window length", lastPause, PCYC);

    // R7 leading wait dropped
    hookCycle();
    quietSum = 0;
    quiet(K_STORE); quiet(K_RP); quiet(5'd3); quiet(K_STORE); quiet(K_M3);
    check(quietSum == 0, "R7", "store output count", quietSum, 0);
    pressKey(K_M3);
    drain();
    expClear(); expAdd(4'd3);
    checkSeq("R7");

    // R8 store of dialled digits
    hookCycle();
    pressKey(5'd6); drain();
    pressKey(5'd9); drain();
    quietSum = 0;
    quiet(K_STORE); quiet(K_STORE); quiet(K_M1);
    check(quietSum == 0, "R8", "store output count", quietSum, 0);
    pressKey(K_M1);
    drain();
    expClear(); expAdd(4'd6); expAdd(4'd9);
    checkSeq("R8");

    // R11 two-key slot
    hookCycle();
    quietSum = 0;
    quiet(K_STORE); quiet(5'd5); quiet(5'd5); quiet(K_STORE); quiet(K_IND); quiet(5'd4);
    check(quietSum == 0, "R11", "store output count", quietSum, 0);
    pressKey(K_IND); drain();
    pressKey(5'd4);
    drain();
    expClear(); expAdd(4'd5); expAdd(4'd5);
    checkSeq("R11");

    // R9 cancel by flash
    hookCycle();
    quietSum = 0;
    quiet(K_STORE); quiet(5'd1);
    check(quietSum == 0, "R9", "digits inside store silent", quietSum, 0);
    flashDone = 1'b1;
    @(negedge clk);
    flashDone = 1'b0;
    pressKey(5'd2);
    drain();
    expClear(); expAdd(4'd2);
    checkSeq("R9");
    // R9 cancel by hook change
    hookCycle();
    quiet(K_STORE); quiet(5'd3);
    hookCycle();
    pressKey(5'd4);
    drain();
    expClear(); expAdd(4'd4);
    checkSeq("R9");

    // R12 key during playback ignored
    hookCycle();
    digitReady = 1'b0;
    pressKey(K_M2);
    pressKey(5'd9);
    drain();
    expClear(); expAdd(4'd4); expAdd(4'd2); expAdd(4'd12); expAdd(4'd8);
    checkSeq("R12");

    // R5 exactly DEPTH entries
    hookCycle();
    expClear();
    for (int i = 0; i < DEPTH; i++) begin
      pressKey(5'(i % 10));
      drain();
      expAdd(4'(i % 10));
    end
    hookCycle();
    pressKey(K_RP);
    drain();
    checkSeq("R5");
    // R5 one beyond DEPTH
    hookCycle();
    for (int i = 0; i <= DEPTH; i++) begin
      pressKey(5'(i % 10));
      drain();
    end
    hookCycle();
    pressKey(K_RP);
    drain();
    check(obsN == 0, "R5", "redial after overflow output count", obsN, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule